// File: doc/BRIEF.md
# Key-Sequence FSM Activation Lock

This block places a small functional state machine behind a layer of locking states that live in the same state register space. While reset is held, a seed input, standing in for a stable chip-unique random response, is captured and picks one of sixteen locked entry paths. The captured seed selects the path. Each path is three key words deep. Only the three correct words, given in order, move the machine into the functional idle state. A wrong word sends it back to the start of its path. Until then the wrapped machine is held idle, its outputs are XOR-ed with a fixed nonzero mask, and the `locked` flag stays high.

After the last correct word the lock opens for good. The flag drops, the outputs are passed through unmasked, and the functional machine steps through its four phases on an advance strobe. Only a new reset closes the lock again. Each seed bit added doubles the number of locked states, while the key path grows only in depth.

Top module: `seqlock_top`

## Requirements
- R1: In the first cycle after reset is released, `locked` is 1 and the functional phase is idle (phase 0).
- R2: The seed is taken from `seed_in` only while `rst` is high. Later changes on `seed_in` do not change which key path unlocks the block.
- R3: For captured seed s, key word k (k = 0, 1, 2) is ((s*0x11) XOR 0xA5) + k*0x3B, taken modulo 256. A word is accepted when `key_vld` is 1 at a clock edge. After the three words are accepted in order, `locked` reads 0 from the next cycle on.
- R4: A wrong word accepted at any step sends the machine back to step 0 of its path. The words that would have followed do not unlock it.
- R5: Cycles with `key_vld` at 0 leave the key progress unchanged, so gaps between words are allowed.
- R6: While locked, `{out_phase, out_word}` equals the functional value XOR 0x2B6. So `out_phase` is inverted in bit 1 and `out_word` is XOR-ed with 0xB6.
- R7: While locked, `adv` has no effect and the functional phase stays at idle.
- R8: Once unlocked, the block stays unlocked until the next reset. Words on `key_word`, right or wrong, then have no effect.
- R9: When unlocked, each cycle with `adv` at 1 steps the phase 0→1→2→3→0. `out_phase` shows the phase, and `out_word` is `din` XOR the phase code. The codes are 0x00, 0x3C, 0xC3 and 0xFF for phases 0 to 3. `out_word` follows `din` in the same cycle.
- R10: An `adv` pulse given in the same cycle as the final key word is not acted on, and the phase is 0 when the lock opens.
- R11: A reset after unlocking closes the lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the seed |
| seed_in | input | 4 | Chip-unique seed, sampled while reset is high |
| key_vld | input | 1 | Marks `key_word` as valid this cycle |
| key_word | input | 8 | Key word input |
| adv | input | 1 | Advance strobe for the functional machine |
| din | input | 8 | Data combined with the phase code |
| out_phase | output | 2 | Functional phase, masked while locked |
| out_word | output | 8 | Functional data word, masked while locked |
| locked | output | 1 | 1 while the lock is closed |

## Verification
The final key word and an advance strobe can arrive on the same clock edge. The lock opens at that edge, but the functional machine is still held, so it must not step. The bench sweeps all sixteen seeds and raises `adv` together with the last word on odd seeds. In each case it judges that `out_phase` reads 0 and `out_word` equals `din`, unmasked, in the cycle after the lock opens.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;

    localparam int SEED_W_DEF  = 4;
    localparam int KEY_W_DEF   = 8;
    localparam int KEY_LEN_DEF = 3;
    localparam int DATA_W_DEF  = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_HOLD  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    // Successor of a functional phase (wraps after the last one).
    function automatic phase_e phase_next(phase_e p);
        phase_e n;
        case (p)
            PH_IDLE:  n = PH_FILL;
            PH_FILL:  n = PH_HOLD;
            PH_HOLD:  n = PH_DRAIN;
            default:  n = PH_IDLE;
        endcase
        return n;
    endfunction

    // Secret key word for a seed and a position on its path (32-bit, sliced by the user).
    function automatic logic [31:0] key_word_of(logic [31:0] seed, logic [31:0] idx);
        return ((seed * 32'h11) ^ 32'hA5) + idx * 32'h3B;
    endfunction

    // One bit of the per-phase data code: 0x00, 0x3C, 0xC3, 0xFF repeated per byte.
    function automatic logic code_bit(phase_e p, int unsigned bitpos);
        logic mid;
        mid = ((bitpos % 8) >= 2) && ((bitpos % 8) <= 5);
        case (p)
            PH_IDLE:  return 1'b0;
            PH_FILL:  return mid;
            PH_HOLD:  return !mid;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/seqlock_keyrom.sv
module seqlock_keyrom
    import seqlock_pkg::*;
#(
    parameter int SEED_W  = SEED_W_DEF,
    parameter int KEY_W   = KEY_W_DEF,
    parameter int KEY_LEN = KEY_LEN_DEF,
    parameter int STEP_W  = 2
) (
    input  logic [SEED_W-1:0] seed,
    input  logic [STEP_W-1:0] step,
    output logic [KEY_W-1:0]  exp_key
);

    logic [KEY_W-1:0] words [KEY_LEN];

    // One computed key word per position on the path.
    for (genvar k = 0; k < KEY_LEN; k++) begin : g_word
        logic [31:0] full;
        assign full     = key_word_of(32'(seed), 32'(k));
        assign words[k] = full[KEY_W-1:0];
    end

    always_comb begin
        exp_key = '0;
        for (int k = 0; k < KEY_LEN; k++) begin
            if (step == STEP_W'(k)) begin
                exp_key = words[k];
            end
        end
    end

endmodule

// File: rtl/seqlock_lockfsm.sv
module seqlock_lockfsm #(
    parameter int SEED_W  = 4,
    parameter int KEY_W   = 8,
    parameter int KEY_LEN = 3,
    parameter int STEP_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEED_W-1:0] seed_in,
    input  logic              key_vld,
    input  logic [KEY_W-1:0]  key_word,
    input  logic [KEY_W-1:0]  exp_key,
    output logic              lock_q,
    output logic [SEED_W-1:0] seed_q,
    output logic [STEP_W-1:0] step_q
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

    logic word_ok;
    assign word_ok = (key_word == exp_key);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
            seed_q <= seed_in;
            step_q <= '0;
        end else if (lock_q && key_vld) begin
            if (!word_ok) begin
                step_q <= '0;
            end else if (step_q == LAST_STEP) begin
                lock_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    a_r1_locked_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lock_q);

    a_r2_seed_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(seed_q));

    a_r3_last_word_opens: assert property (@(posedge clk) disable iff (rst)
        (lock_q && key_vld && word_ok && step_q == LAST_STEP) |=> !lock_q);

    a_r4_wrong_word_restarts: assert property (@(posedge clk) disable iff (rst)
        (lock_q && key_vld && !word_ok) |=> (lock_q && step_q == '0));

    a_r5_gap_holds_progress: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !key_vld) |=> (lock_q && $stable(step_q)));

    a_r8_open_stays_open: assert property (@(posedge clk) disable iff (rst)
        !lock_q |=> !lock_q);

endmodule

// File: rtl/seqlock_core.sv
module seqlock_core
    import seqlock_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    output phase_e            phase_q,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] code;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            phase_q <= PH_IDLE;
        end else if (adv) begin
            phase_q <= phase_next(phase_q);
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_code
        assign code[i] = code_bit(phase_q, i);
    end

    assign word = din ^ code;

    a_r7_idle_while_held: assert property (@(posedge clk) disable iff (rst)
        hold |-> phase_q == PH_IDLE);

    a_r9_advance_steps: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv) |=> phase_q == phase_next($past(phase_q)));

    a_r10_open_at_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> phase_q == PH_IDLE);

endmodule

// File: rtl/seqlock_gate.sv
module seqlock_gate #(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W+1:0] MASK = '1
) (
    input  logic              locked,
    input  logic [1:0]        f_phase,
    input  logic [DATA_W-1:0] f_word,
    output logic [1:0]        o_phase,
    output logic [DATA_W-1:0] o_word
);

    localparam int OUT_W = DATA_W + 2;

    logic [OUT_W-1:0] func_bus;
    logic [OUT_W-1:0] out_bus;

    assign func_bus = {f_phase, f_word};

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (MASK[i]) begin : g_flip
            assign out_bus[i] = func_bus[i] ^ locked;
        end else begin : g_pass
            assign out_bus[i] = func_bus[i];
        end
    end

    assign {o_phase, o_word} = out_bus;

endmodule

// File: rtl/seqlock_top.sv
module seqlock_top
    import seqlock_pkg::*;
#(
    parameter int SEED_W  = SEED_W_DEF,
    parameter int KEY_W   = KEY_W_DEF,
    parameter int KEY_LEN = KEY_LEN_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter logic [DATA_W+1:0] CORRUPT_MASK = (DATA_W + 2)'('h2B6)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEED_W-1:0] seed_in,
    input  logic              key_vld,
    input  logic [KEY_W-1:0]  key_word,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    output logic [1:0]        out_phase,
    output logic [DATA_W-1:0] out_word,
    output logic              locked
);

    localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    logic [SEED_W-1:0] seed_q;
    logic [STEP_W-1:0] step_q;
    logic [KEY_W-1:0]  exp_key;
    logic              lock_q;
    phase_e            f_phase;
    logic [DATA_W-1:0] f_word;

    seqlock_keyrom #(
        .SEED_W (SEED_W),
        .KEY_W  (KEY_W),
        .KEY_LEN(KEY_LEN),
        .STEP_W (STEP_W)
    ) u_keyrom (
        .seed   (seed_q),
        .step   (step_q),
        .exp_key(exp_key)
    );

    seqlock_lockfsm #(
        .SEED_W (SEED_W),
        .KEY_W  (KEY_W),
        .KEY_LEN(KEY_LEN),
        .STEP_W (STEP_W)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .seed_in (seed_in),
        .key_vld (key_vld),
        .key_word(key_word),
        .exp_key (exp_key),
        .lock_q  (lock_q),
        .seed_q  (seed_q),
        .step_q  (step_q)
    );

    seqlock_core #(
        .DATA_W(DATA_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .hold   (lock_q),
        .adv    (adv),
        .din    (din),
        .phase_q(f_phase),
        .word   (f_word)
    );

    seqlock_gate #(
        .DATA_W(DATA_W),
        .MASK  (CORRUPT_MASK)
    ) u_gate (
        .locked (lock_q),
        .f_phase(f_phase),
        .f_word (f_word),
        .o_phase(out_phase),
        .o_word (out_word)
    );

    assign locked = lock_q;

endmodule

// File: tb/sim_seqlock_top.sv
module sim_seqlock_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] seed_in = '0;
    logic       key_vld = 1'b0;
    logic [7:0] key_word = '0;
    logic       adv = 1'b0;
    logic [7:0] din = '0;
    logic [1:0] out_phase;
    logic [7:0] out_word;
    logic       locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seqlock_top u0 (
        .clk      (clk),
        .rst      (rst),
        .seed_in  (seed_in),
        .key_vld  (key_vld),
        .key_word (key_word),
        .adv      (adv),
        .din      (din),
        .out_phase(out_phase),
        .out_word (out_word),
        .locked   (locked)
    );

    function automatic logic [7:0] kexp(int s, int k);
        return 8'(((s * 17) ^ 165) + k * 59);
    endfunction

    function automatic logic [7:0] pcode(int p);
        case (p % 4)
            0:       return 8'h00;
            1:       return 8'h3C;
            2:       return 8'hC3;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic do_reset(int s);
        rst = 1'b1; seed_in = 4'(s); key_vld = 1'b0; adv = 1'b0;
        tick; tick;
        rst = 1'b0;
        #1;
    endtask

    task automatic send_key(int w, bit a);
        key_vld = 1'b1; key_word = 8'(w); adv = a;
        tick;
        key_vld = 1'b0; adv = 1'b0;
        #1;
    endtask

    task automatic expect_locked(string tag);
        check({tag, " R1/R11 locked flag"}, locked, 1);
        check({tag, " R6 masked phase"}, out_phase, 2);
        check({tag, " R6 masked word"}, out_word, din ^ 8'hB6);
    endtask

    task automatic unlock_with(int s);
        for (int k = 0; k < 3; k++) send_key(kexp(s, k), 1'b0);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary;
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(0);
        din = 8'h5A; #1;
        expect_locked("reset");

        // Sweep all seeds: R2, R3, R5, R6, R10
        for (int s = 0; s < 16; s++) begin
            do_reset(s);
            seed_in = 4'(15 - s);          // R2: port changes after reset ignored
            din = 8'(s * 13 + 7); #1;
            expect_locked("sweep");
            send_key(kexp(s, 0), 1'b0);
            check("R3 locked after word 0", locked, 1);
            tick; tick; #1;                 // R5: gap without key_vld
            check("R5 gap keeps lock", locked, 1);
            send_key(kexp(s, 1), 1'b0);
            check("R3 locked after word 1", locked, 1);
            send_key(kexp(s, 2), 1'(s % 2)); // R10: adv with last word on odd seeds
            check("R3 unlocked after word 2", locked, 0);
            check("R10 phase idle at opening", out_phase, 0);
            check("R9 unmasked idle word", out_word, din);
        end

        // R4: wrong word at each step
        for (int p = 0; p < 3; p++) begin
            do_reset(5);
            for (int k = 0; k < p; k++) send_key(kexp(5, k), 1'b0);
            send_key(kexp(5, p) ^ 8'h01, 1'b0);
            for (int k = p + 1; k < 3; k++) send_key(kexp(5, k), 1'b0);
            check("R4 wrong word keeps lock", locked, 1);
            unlock_with(5);
            check("R4 full path after restart opens", locked, 0);
        end

        // R2: another seed's path does not open
        do_reset(3);
        seed_in = 4'd9; #1;
        unlock_with(9);
        check("R2 foreign path stays locked", locked, 1);
        unlock_with(3);
        check("R2 captured path opens", locked, 0);

        // R7: adv ignored while locked
        do_reset(7);
        din = 8'h81;
        for (int i = 0; i < 5; i++) begin
            adv = 1'b1; tick; adv = 1'b0; #1;
            check("R7 phase held while locked", out_phase, 2);
        end
        unlock_with(7);
        check("R7 phase idle after unlock", out_phase, 0);

        // R9: functional sequence
        for (int i = 0; i < 8; i++) begin
            din = 8'(i * 37 + 3);
            adv = 1'b1; tick; adv = 1'b0; #1;
            check("R9 phase step", out_phase, (i + 1) % 4);
            check("R9 word code", out_word, din ^ pcode(i + 1));
        end
        din = 8'hE4; #1;
        check("R9 word follows din", out_word, 8'hE4 ^ pcode(0));

        // R8: key inputs ignored once open
        send_key(8'h00, 1'b0);
        send_key(kexp(7, 0) ^ 8'h10, 1'b0);
        unlock_with(2);
        check("R8 stays unlocked", locked, 0);
        check("R8 phase untouched", out_phase, 0);

        // R11: reset closes the lock again
        din = 8'h3F;
        do_reset(12);
        expect_locked("relock");

        done = 1'b1;
        summary;
        $finish;
    end

endmodule